// File: doc/BRIEF.md
# Battery Temperature Charge Qualifier

This block decides, from the battery thermistor, whether the charge controller may charge. Three comparator flags report where the battery temperature sits against three limits: colder than the low limit, warmer than the upper start limit, and warmer than the upper cut-off limit. The cut-off limit lies above the start limit. A charging-active indication from the charge controller and a one-cycle millisecond tick complete the inputs. The single output, `temp_ok`, is a registered permit: 1 lets charging proceed and 0 suspends it.

The allowed temperature range depends on the state of the charge. Charging may only start, or restart after a suspend, inside the narrow range between the low limit and the upper start limit. Once permitted and actively charging, the upper bound relaxes to the cut-off limit, so a battery that warms during charge is not cut off at once. Leaving the allowed range is filtered by a short persistence interval. Returning to it is filtered by a much longer one. A persistence count restarts from zero whenever its condition lapses before the interval completes. The comparator flags are resynchronised through two flip-flop stages before any evaluation.

Top module: `batt_temp_qual`

## Requirements
- R1: A reset forces `temp_ok` to 0, and it remains 0 until the resume rule (R2) has been met.
- R2: While `temp_ok` is 0, `temp_ok` becomes 1 only after the temperature has been in the narrow range (flags `ts_cold`=0 and `ts_hot`=0) on RESUME_MS consecutive ticks. The default is 400. After RESUME_MS-1 such ticks it is still 0.
- R3: While `temp_ok` is 1 and `chg_active` is 1, a temperature above the start limit but below the cut-off limit (`ts_hot`=1, `ts_cutoff`=0, `ts_cold`=0) never clears `temp_ok`, however many ticks pass.
- R4: While `temp_ok` is 1 and `chg_active` is 0, `ts_hot`=1 held on SUSPEND_MS consecutive ticks clears `temp_ok`. The default is 20.
- R5: While `temp_ok` is 1, `ts_cold`=1 held on SUSPEND_MS consecutive ticks clears `temp_ok`. After SUSPEND_MS-1 such ticks it is still 1.
- R6: While `temp_ok` is 1 and `chg_active` is 1, `ts_cutoff`=1 held on SUSPEND_MS consecutive ticks clears `temp_ok`. After SUSPEND_MS-1 such ticks it is still 1.
- R7: While `temp_ok` is 0, a temperature between the start and cut-off limits does not restore `temp_ok`, even with `chg_active`=1.
- R8: If the qualifying condition is absent on any clock before its interval completes, the persistence count restarts from zero. This applies in both directions.
- R9: `temp_ok` changes only on the clock edge at which `tick_ms` is 1. A flag change must be held for two clocks before it takes effect, because of the resynchronisation stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_cold | input | 1 | 1 = battery colder than the low limit (asynchronous) |
| ts_hot | input | 1 | 1 = battery warmer than the upper start limit (asynchronous) |
| ts_cutoff | input | 1 | 1 = battery warmer than the upper cut-off limit (asynchronous) |
| chg_active | input | 1 | 1 = the charge controller is charging (synchronous) |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| temp_ok | output | 1 | 1 = charging permitted, 0 = suspended |

## Verification
The assertions assume that `tick_ms` is a single-cycle pulse from the same clock domain. They also assume that `chg_active` is synchronous, and that the flags are physically consistent, so `ts_cutoff`=1 implies `ts_hot`=1 and cold never coincides with hot. The stimulus only applies the four legal temperature classes: cold, normal, warm and over-limit. It changes a flag at a falling edge and then waits several clocks, with no tick, before counting ticks. This keeps synchroniser latency out of every interval. Ticks are spaced two clocks apart, so each tick is a distinct, single-cycle event.

// File: rtl/batt_temp_pkg.sv
package batt_temp_pkg;

  typedef struct packed {
    logic cold;
    logic hot;
    logic cutoff;
  } ts_flags_t;

  localparam int unsigned FLAG_W = $bits(ts_flags_t);

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/bt_window.sv
module bt_window
  import batt_temp_pkg::*;
(
  input  ts_flags_t flags,
  input  logic      permit,
  input  logic      charging,
  output logic      in_narrow,
  output logic      qualify
);

  logic out_wide;
  logic out_narrow;

  always_comb begin
    in_narrow  = !(flags.cold || flags.hot);
    out_narrow = !in_narrow;
    out_wide   = flags.cold || flags.cutoff;
    if (permit) qualify = charging ? out_wide : out_narrow;
    else        qualify = in_narrow;
  end

endmodule

// File: rtl/bt_persist.sv
module bt_persist #(
  parameter int unsigned SUSPEND_MS = 20,
  parameter int unsigned RESUME_MS  = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic permit,
  input  logic qualify,
  input  logic tick,
  output logic expire
);

  localparam int unsigned MAXL = batt_temp_pkg::max_u(SUSPEND_MS, RESUME_MS);
  localparam int unsigned CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] LIM_SUS = CW'(SUSPEND_MS);
  localparam logic [CW-1:0] LIM_RES = CW'(RESUME_MS);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim    = permit ? LIM_SUS : LIM_RES;
  assign expire = qualify && tick && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || expire || !qualify) cnt <= '0;
    else if (tick)                 cnt <= cnt + 1'b1;
  end

  // R8: the count never reaches the active interval length
  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt < lim);

  // R8: a lapse of the qualifying condition restarts the count
  p_lapse_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !qualify |=> (cnt == '0));

  // R9: the count only advances on a tick
  p_count_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && cnt != $past(cnt) && $past(cnt) != '0) |-> $past(tick));

endmodule

// File: rtl/batt_temp_qual.sv
module batt_temp_qual
  import batt_temp_pkg::*;
#(
  parameter int unsigned SUSPEND_MS  = 20,
  parameter int unsigned RESUME_MS   = 400,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ts_cold,
  input  logic ts_hot,
  input  logic ts_cutoff,
  input  logic chg_active,
  input  logic tick_ms,
  output logic temp_ok
);

  ts_flags_t raw_flags;
  ts_flags_t sync_flags;
  logic      in_narrow;
  logic      qualify;
  logic      expire;

  assign raw_flags = '{cold: ts_cold, hot: ts_hot, cutoff: ts_cutoff};

  bt_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_flags),
    .q   (sync_flags)
  );

  bt_window u_window (
    .flags     (sync_flags),
    .permit    (temp_ok),
    .charging  (chg_active),
    .in_narrow (in_narrow),
    .qualify   (qualify)
  );

  bt_persist #(.SUSPEND_MS(SUSPEND_MS), .RESUME_MS(RESUME_MS)) u_persist (
    .clk     (clk),
    .rst     (rst),
    .permit  (temp_ok),
    .qualify (qualify),
    .tick    (tick_ms),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst)         temp_ok <= 1'b0;
    else if (expire) temp_ok <= !temp_ok;
  end

  // R1: reset leaves the permit withdrawn
  p_reset_suspends_r1: assert property (@(posedge clk)
    rst |=> !temp_ok);

  // R2, R7: a permit is only granted from inside the narrow range
  p_grant_in_narrow_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(temp_ok) |-> $past(in_narrow));

  // R9: the permit changes only on a tick edge
  p_change_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(temp_ok) |-> $past(tick_ms));

  // R3: no withdrawal while charging inside the widened range
  p_wide_holds_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(temp_ok) && $past(chg_active)) |-> $past(sync_flags.cold || sync_flags.cutoff));

endmodule

// File: tb/batt_temp_qual_test.sv
module batt_temp_qual_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ts_cold = 1'b0;
  logic ts_hot = 1'b0;
  logic ts_cutoff = 1'b0;
  logic chg_active = 1'b0;
  logic tick_ms = 1'b0;
  logic temp_ok;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam int SUS = 20;
  localparam int RES = 400;

  always #2.5 clk = ~clk;

  batt_temp_qual uut (
    .clk(clk), .rst(rst), .ts_cold(ts_cold), .ts_hot(ts_hot),
    .ts_cutoff(ts_cutoff), .chg_active(chg_active), .tick_ms(tick_ms),
    .temp_ok(temp_ok)
  );

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (temp_ok !== exp) begin
      n_fail++;
      $display("FAIL %s: temp_ok=%b expected %b", req, temp_ok, exp);
    end
  endtask

  // classes: 0 normal, 1 cold, 2 warm (above start, below cut-off), 3 over cut-off
  task automatic set_temp(input int cls);
    @(negedge clk);
    ts_cold   = (cls == 1);
    ts_hot    = (cls >= 2);
    ts_cutoff = (cls == 3);
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_and_resume();
    do_reset();
    check("R1 reset state", 1'b0);
    set_temp(0);
    ticks(RES - 1);
    check("R1 R2 not yet resumed", 1'b0);
    ticks(1);
    check("R2 resumed", 1'b1);
  endtask

  task automatic t_wide_window();
    chg_active = 1'b1;
    set_temp(2);
    ticks(3 * SUS);
    check("R3 warm while charging", 1'b1);
  endtask

  task automatic t_cutoff();
    set_temp(3);
    ticks(SUS - 1);
    check("R6 before interval", 1'b1);
    ticks(1);
    check("R6 suspended", 1'b0);
  endtask

  task automatic t_narrow_resume();
    set_temp(2);
    ticks(RES + 10);
    check("R7 warm does not resume", 1'b0);
    set_temp(0);
    ticks(RES);
    check("R2 resume from normal", 1'b1);
  endtask

  task automatic t_idle_hot();
    chg_active = 1'b0;
    set_temp(2);
    ticks(SUS - 1);
    check("R4 before interval", 1'b1);
    ticks(1);
    check("R4 suspended", 1'b0);
    set_temp(0);
    ticks(RES);
    check("R2 resume again", 1'b1);
  endtask

  task automatic t_cold_restart();
    chg_active = 1'b1;
    set_temp(1);
    ticks(SUS - 1);
    check("R5 before interval", 1'b1);
    set_temp(0);
    ticks(2);
    set_temp(1);
    ticks(SUS - 1);
    check("R8 suspend count restarted", 1'b1);
    ticks(1);
    check("R5 suspended", 1'b0);
  endtask

  task automatic t_resume_restart();
    set_temp(0);
    ticks(RES - 1);
    check("R8 resume pending", 1'b0);
    set_temp(1);
    ticks(1);
    set_temp(0);
    ticks(RES - 1);
    check("R8 resume count restarted", 1'b0);
    ticks(1);
    check("R2 resume after restart", 1'b1);
  endtask

  task automatic t_no_tick();
    chg_active = 1'b0;
    set_temp(2);
    repeat (200) @(negedge clk);
    check("R9 no change without tick", 1'b1);
    ticks(SUS);
    check("R9 change after ticks", 1'b0);
    set_temp(0);
    ticks(RES);
    check("R2 resumed before reset", 1'b1);
    do_reset();
    check("R1 reset clears permit", 1'b0);
  endtask

  initial begin
    t_reset_and_resume();
    t_wide_window();
    t_cutoff();
    t_narrow_resume();
    t_idle_hot();
    t_cold_restart();
    t_resume_restart();
    t_no_tick();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule